// File: doc/BRIEF.md
# Double-Buffered DMA Channel Controller

This block holds six identical DMA channels behind a 32-bit register bus. Each channel keeps a device configuration word, a control/status byte, and two transfer descriptors (buffer A and buffer B), each made of a start address and a byte count. Software loads a descriptor and then marks it ready. The channel works through the ready buffers in alternation. A buffer-in-use flag selects which descriptor is active.

While its device request input is high and the active buffer is ready, a channel issues one burst at a time on a shared request/acknowledge memory port. A fixed-priority arbiter decides which channel owns that port. When a buffer's count reaches zero, the channel retires that buffer, flags it done, and turns to the other buffer. A per-channel interrupt reports done and error conditions. The memory port carries a memory-side error response, which halts the channel that issued the burst.

Top module: `dmac_top`

## Requirements
- R1: Register k (0..7) of channel c sits at byte address c*0x20 + k*4. The order is config, status-set, status-clear, status-read, start-A, count-A, start-B, count-B. Config, start and count registers read back the last value written. An address whose channel index is 6 or 7 reads 0.
- R2: The status byte holds RUN at bit 0, IE at bit 1, ERROR at bit 2, DONE-A at bit 3, START-A at bit 4, DONE-B at bit 5, START-B at bit 6, and BIU at bit 7. A 1 written to the set address sets that bit. A 1 written to the clear address clears it. The status-read address returns the live byte.
- R3: Writing 0xFF to the clear address zeroes the status byte and drops the interrupt. After any burst already outstanding, the channel starts no new burst.
- R4: While RUN is set, ERROR is clear, the active buffer's start bit is set and the device request is high, the channel issues bursts of (config bit 2 ? 8 : 4) × (config bit 3 ? 2 : 1) bytes. Each accepted burst advances the address and lowers the count by the burst length. A final burst is cut down to the bytes remaining. mem_write equals config bit 0.
- R5: BIU = 0 makes buffer A active, and BIU = 1 makes buffer B active. With both buffers armed, A is consumed first and then B.
- R6: When the active buffer's count is zero, the channel clears that buffer's start bit, sets its done bit and inverts BIU, with no memory access. This also applies to a buffer armed with a zero count.
- R7: irq[c] is high exactly when IE is set and at least one of DONE-A, DONE-B or ERROR is set.
- R8: A channel whose active buffer has its start bit clear issues no burst, even with the request high. It resumes once software sets that start bit.
- R9: An error response on the memory port sets ERROR and clears RUN, and leaves the address and count unchanged. No burst follows until software clears ERROR and sets RUN again.
- R10: Only one channel owns the memory port at a time. Among simultaneous requesters, the lowest channel index goes first, and a grant is held until its burst is acknowledged.
- R11: A software write to the set or clear address lands on top of the hardware update made in the same cycle. Bits the write does not name keep the hardware result.
- R12: After reset, every register reads 0, no irq is high and mem_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| dev_req | input | 6 | Per-channel device request |
| mem_req | output | 1 | Memory burst request |
| mem_chan | output | 3 | Channel owning the current burst |
| mem_addr | output | 32 | Burst start address |
| mem_len | output | 5 | Burst length in bytes |
| mem_write | output | 1 | 1 = write to memory (data comes from the device) |
| mem_ack | input | 1 | Burst accepted |
| mem_err | input | 1 | Error response, valid with mem_ack |
| irq | output | 6 | Per-channel interrupt |

## Verification
The key collision is between buffer retirement and a software write to the status byte, when both fall in the same clock. In that cycle the hardware clears START-A, sets DONE-A and flips BIU, while software sets START-B. The bench sets this up by arming buffer A with a zero count. It then issues two back-to-back status-set writes, so that the second write meets the retirement cycle exactly. The result passes only if the status byte shows the hardware changes and the new START-B together, and no memory burst appears.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam logic [2:0] REG_CFG  = 3'd0;
    localparam logic [2:0] REG_SET  = 3'd1;
    localparam logic [2:0] REG_CLR  = 3'd2;
    localparam logic [2:0] REG_STAT = 3'd3;
    localparam logic [2:0] REG_ADRA = 3'd4;
    localparam logic [2:0] REG_CNTA = 3'd5;
    localparam logic [2:0] REG_ADRB = 3'd6;
    localparam logic [2:0] REG_CNTB = 3'd7;

    // Status byte, MSB first so that bit positions match the register view.
    typedef struct packed {
        logic biu;
        logic strt_b;
        logic done_b;
        logic strt_a;
        logic done_a;
        logic err;
        logic ie;
        logic run;
    } ctl_t;

endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int DW   = 32,
    parameter int LENW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      reg_sel,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic            dev_req,
    output logic            mreq,
    output logic [DW-1:0]   maddr,
    output logic [LENW-1:0] mlen,
    output logic            mwrite,
    input  logic            mack,
    input  logic            merr,
    output logic            irq
);

    typedef struct packed {
        logic [DW-1:0]   cfg;
        ctl_t            ctl;
        logic [DW-1:0]   adr_a;
        logic [DW-1:0]   cnt_a;
        logic [DW-1:0]   adr_b;
        logic [DW-1:0]   cnt_b;
        logic            busy;
        logic            buf_b;
        logic [LENW-1:0] len;
    } chan_t;

    chan_t q, d;

    logic            act_b;
    logic            act_start;
    logic [DW-1:0]   act_cnt;
    logic [LENW-1:0] burst;
    logic            can_go;

    always_comb begin
        d         = q;
        act_b     = q.ctl.biu;
        act_start = act_b ? q.ctl.strt_b : q.ctl.strt_a;
        act_cnt   = act_b ? q.cnt_b : q.cnt_a;
        burst     = q.cfg[2] ? LENW'(8) : LENW'(4);
        if (q.cfg[3]) burst = burst << 1;
        can_go    = q.ctl.run && !q.ctl.err && act_start && !q.busy;

        // hardware sequencing
        if (q.busy && mack) begin
            d.busy = 1'b0;
            if (merr) begin
                d.ctl.err = 1'b1;
                d.ctl.run = 1'b0;
            end else if (q.buf_b) begin
                d.adr_b = q.adr_b + DW'(q.len);
                d.cnt_b = q.cnt_b - DW'(q.len);
            end else begin
                d.adr_a = q.adr_a + DW'(q.len);
                d.cnt_a = q.cnt_a - DW'(q.len);
            end
        end else if (can_go && act_cnt == '0) begin
            if (act_b) begin
                d.ctl.strt_b = 1'b0;
                d.ctl.done_b = 1'b1;
            end else begin
                d.ctl.strt_a = 1'b0;
                d.ctl.done_a = 1'b1;
            end
            d.ctl.biu = ~q.ctl.biu;
        end else if (can_go && dev_req) begin
            d.busy  = 1'b1;
            d.buf_b = act_b;
            d.len   = (act_cnt < DW'(burst)) ? act_cnt[LENW-1:0] : burst;
        end

        // software writes layered on top of the hardware result
        if (wr_en) begin
            case (reg_sel)
                REG_CFG:  d.cfg   = wdata;
                REG_SET:  d.ctl   = ctl_t'(d.ctl | wdata[7:0]);
                REG_CLR:  d.ctl   = ctl_t'(d.ctl & ~wdata[7:0]);
                REG_ADRA: d.adr_a = wdata;
                REG_CNTA: d.cnt_a = wdata;
                REG_ADRB: d.adr_b = wdata;
                REG_CNTB: d.cnt_b = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_sel)
            REG_CFG:  rdata = q.cfg;
            REG_ADRA: rdata = q.adr_a;
            REG_CNTA: rdata = q.cnt_a;
            REG_ADRB: rdata = q.adr_b;
            REG_CNTB: rdata = q.cnt_b;
            default:  rdata = DW'(q.ctl);
        endcase
    end

    assign mreq   = q.busy;
    assign maddr  = q.buf_b ? q.adr_b : q.adr_a;
    assign mlen   = q.len;
    assign mwrite = q.cfg[0];
    assign irq    = q.ctl.ie && (q.ctl.done_a || q.ctl.done_b || q.ctl.err);

    // R9
    err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && mack && merr && !wr_en) |=> (q.ctl.err && !q.ctl.run));

    // R4
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.len != '0 && q.len <= LENW'(16)));

    // R8
    armed_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(q.ctl.biu ? q.ctl.strt_b : q.ctl.strt_a));

endmodule

// File: rtl/dmac_arb.sv
module dmac_arb #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic           ack,
    output logic [NCH-1:0] gnt,
    output logic           mem_req_o
);

    logic [NCH-1:0] gnt_q, gnt_d;
    logic [NCH-1:0] live;

    always_comb begin
        gnt_d = gnt_q;
        live  = req & ~(ack ? gnt_q : '0);
        if (((gnt_q & req) == '0) || ack) begin
            gnt_d = '0;
            for (int i = NCH - 1; i >= 0; i--) begin
                if (live[i]) gnt_d = NCH'(1) << i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gnt_q <= '0;
        else        gnt_q <= gnt_d;
    end

    assign gnt       = gnt_q;
    assign mem_req_o = |(req & gnt_q);

    // R10
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_q));

    // R10
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !ack) |=> $stable(gnt_q));

endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int NCH  = 6,
    parameter int DW   = 32,
    parameter int LENW = 5,
    localparam int CHW = $clog2(NCH),
    localparam int AW  = CHW + 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NCH-1:0]  dev_req,
    output logic            mem_req,
    output logic [CHW-1:0]  mem_chan,
    output logic [DW-1:0]   mem_addr,
    output logic [LENW-1:0] mem_len,
    output logic            mem_write,
    input  logic            mem_ack,
    input  logic            mem_err,
    output logic [NCH-1:0]  irq
);

    logic [CHW-1:0]  sel_ch;
    logic [2:0]      sel_reg;
    logic [DW-1:0]   ch_rdata [NCH];
    logic [DW-1:0]   ch_addr  [NCH];
    logic [LENW-1:0] ch_len   [NCH];
    logic [NCH-1:0]  ch_req, ch_wr, gnt;

    assign sel_ch  = reg_addr[AW-1:5];
    assign sel_reg = reg_addr[4:2];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dmac_chan #(.DW(DW), .LENW(LENW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_we && sel_ch == CHW'(c)),
            .reg_sel (sel_reg),
            .wdata   (reg_wdata),
            .rdata   (ch_rdata[c]),
            .dev_req (dev_req[c]),
            .mreq    (ch_req[c]),
            .maddr   (ch_addr[c]),
            .mlen    (ch_len[c]),
            .mwrite  (ch_wr[c]),
            .mack    (mem_ack && gnt[c]),
            .merr    (mem_err),
            .irq     (irq[c])
        );
    end

    dmac_arb #(.NCH(NCH)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ch_req),
        .ack       (mem_ack),
        .gnt       (gnt),
        .mem_req_o (mem_req)
    );

    always_comb begin
        reg_rdata = '0;
        mem_addr  = '0;
        mem_len   = '0;
        mem_write = 1'b0;
        mem_chan  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (sel_ch == CHW'(c)) reg_rdata = ch_rdata[c];
            if (gnt[c]) begin
                mem_addr  = ch_addr[c];
                mem_len   = ch_len[c];
                mem_write = ch_wr[c];
                mem_chan  = CHW'(c);
            end
        end
    end

endmodule

// File: tb/tb_dmac_top.sv
module tb_dmac_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  dev_req = '0;
    logic        mem_req;
    logic [2:0]  mem_chan;
    logic [31:0] mem_addr;
    logic [4:0]  mem_len;
    logic        mem_write;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [5:0]  irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic err_inject = 1'b0;

    int          nlog = 0;
    logic [31:0] log_addr [64];
    logic [4:0]  log_len  [64];
    logic [2:0]  log_ch   [64];
    logic        log_wr   [64];

    always #4 clk = ~clk;

    dmac_top dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
        .mem_req(mem_req), .mem_chan(mem_chan), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_write(mem_write), .mem_ack(mem_ack),
        .mem_err(mem_err), .irq(irq)
    );

    // memory stub: acknowledge each request one cycle after it appears
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            mem_err <= err_inject;
            if (nlog < 64) begin
                log_addr[nlog] <= mem_addr;
                log_len[nlog]  <= mem_len;
                log_ch[nlog]   <= mem_chan;
                log_wr[nlog]   <= mem_write;
            end
            nlog <= nlog + 1;
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ra(input int ch, input int r);
        return 8'(ch * 32 + r * 4);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_mask_clear(input int ch, input logic [7:0] mask);
        logic [31:0] s;
        for (int i = 0; i < 400; i++) begin
            rd(ra(ch, 3), s);
            if ((s[7:0] & mask) == 0) break;
        end
    endtask

    task automatic wait_mask_set(input int ch, input logic [7:0] mask);
        logic [31:0] s;
        for (int i = 0; i < 400; i++) begin
            rd(ra(ch, 3), s);
            if ((s[7:0] & mask) != 0) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(ra(0, 3), v);  check("R12 status after reset", v, 0);
        rd(ra(5, 0), v);  check("R12 config after reset", v, 0);
        rd(ra(3, 7), v);  check("R12 count-B after reset", v, 0);
        check("R12 irq after reset", 32'(irq), 0);
        check("R12 mem_req after reset", 32'(mem_req), 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(ra(2, 4), 32'h1234_5678);
        wr(ra(5, 7), 32'h0000_ABCD);
        wr(ra(1, 0), 32'hA5A5_5AF2);
        rd(8'h50, v);     check("R1 ch2 start-A at 0x50", v, 32'h1234_5678);
        rd(8'hBC, v);     check("R1 ch5 count-B at 0xBC", v, 32'h0000_ABCD);
        rd(ra(1, 0), v);  check("R1 ch1 config readback", v, 32'hA5A5_5AF2);
        rd(ra(3, 4), v);  check("R1 ch3 start-A untouched", v, 0);
        rd(8'hE0, v);     check("R1 channel index 7 reads zero", v, 0);
        wr(ra(1, 0), 0);
    endtask

    task automatic t_setclr();
        logic [31:0] v;
        wr(ra(4, 1), 32'h02); rd(ra(4, 3), v); check("R2 set IE", v, 32'h02);
        wr(ra(4, 1), 32'h80); rd(ra(4, 3), v); check("R2 set BIU", v, 32'h82);
        check("R7 irq low with IE but no done", 32'(irq[4]), 0);
        wr(ra(4, 2), 32'h02); rd(ra(4, 3), v); check("R2 clear IE", v, 32'h80);
        wr(ra(4, 2), 32'hFF); rd(ra(4, 3), v); check("R3 clear all", v, 0);
    endtask

    task automatic t_single_and_stall();
        logic [31:0] v;
        int base;
        wr(ra(0, 0), 32'h0);
        wr(ra(0, 4), 32'h1000);
        wr(ra(0, 5), 32'd10);
        base = nlog;
        dev_req[0] = 1'b1;
        wr(ra(0, 1), 32'h13);
        wait_mask_clear(0, 8'h10);
        check("R4 three bursts for count 10", 32'(nlog - base), 3);
        check("R4 burst0 addr", log_addr[base], 32'h1000);
        check("R4 burst1 addr", log_addr[base+1], 32'h1004);
        check("R4 burst2 addr", log_addr[base+2], 32'h1008);
        check("R4 burst0 len", 32'(log_len[base]), 4);
        check("R4 truncated last len", 32'(log_len[base+2]), 2);
        check("R4 direction bit 0 = 0", 32'(log_wr[base]), 0);
        check("R10 channel id", 32'(log_ch[base]), 0);
        rd(ra(0, 3), v);  check("R6 status after A done", v, 32'h8B);
        rd(ra(0, 4), v);  check("R4 start-A advanced", v, 32'h100A);
        rd(ra(0, 5), v);  check("R4 count-A exhausted", v, 0);
        check("R7 irq on done", 32'(irq[0]), 1);
        wr(ra(0, 2), 32'h08);
        #1 check("R7 irq drops after done clear", 32'(irq[0]), 0);
        // B is active but not armed: stall
        base = nlog;
        repeat (20) @(negedge clk);
        check("R8 no burst on unarmed buffer", 32'(nlog - base), 0);
        wr(ra(0, 0), 32'h0D);
        wr(ra(0, 6), 32'h2000);
        wr(ra(0, 7), 32'd20);
        wr(ra(0, 1), 32'h40);
        wait_mask_clear(0, 8'h40);
        check("R8 resume after arming B", 32'(nlog - base), 2);
        check("R4 16-byte burst addr", log_addr[base], 32'h2000);
        check("R4 16-byte burst len", 32'(log_len[base]), 16);
        check("R4 second addr", log_addr[base+1], 32'h2010);
        check("R4 truncated len 4", 32'(log_len[base+1]), 4);
        check("R4 direction bit 0 = 1", 32'(log_wr[base]), 1);
        rd(ra(0, 3), v);  check("R5 BIU back to A after B", v, 32'h23);
        dev_req[0] = 1'b0;
        wr(ra(0, 2), 32'hFF);
    endtask

    task automatic t_pingpong();
        logic [31:0] v;
        int base;
        wr(ra(1, 0), 32'h04);
        wr(ra(1, 4), 32'h3000); wr(ra(1, 5), 32'd8);
        wr(ra(1, 6), 32'h4000); wr(ra(1, 7), 32'd16);
        base = nlog;
        dev_req[1] = 1'b1;
        wr(ra(1, 1), 32'h53);
        wait_mask_clear(1, 8'h50);
        dev_req[1] = 1'b0;
        check("R5 burst count both buffers", 32'(nlog - base), 3);
        check("R5 A first", log_addr[base], 32'h3000);
        check("R5 B next", log_addr[base+1], 32'h4000);
        check("R5 B continues", log_addr[base+2], 32'h4008);
        check("R4 8-byte burst", 32'(log_len[base+1]), 8);
        rd(ra(1, 3), v);  check("R5 both done", v, 32'h2B);
        wr(ra(1, 2), 32'hFF);
    endtask

    task automatic t_arb();
        int base;
        wr(ra(3, 0), 0); wr(ra(3, 4), 32'h6000); wr(ra(3, 5), 32'd4);
        wr(ra(2, 0), 0); wr(ra(2, 4), 32'h5000); wr(ra(2, 5), 32'd4);
        wr(ra(3, 1), 32'h13);
        wr(ra(2, 1), 32'h13);
        base = nlog;
        @(negedge clk);
        dev_req[3:2] = 2'b11;
        wait_mask_clear(2, 8'h10);
        wait_mask_clear(3, 8'h10);
        dev_req[3:2] = 2'b00;
        check("R10 two bursts", 32'(nlog - base), 2);
        check("R10 lower index first", 32'(log_ch[base]), 2);
        check("R10 lower index addr", log_addr[base], 32'h5000);
        check("R10 higher index next", 32'(log_ch[base+1]), 3);
        wr(ra(2, 2), 32'hFF);
        wr(ra(3, 2), 32'hFF);
    endtask

    task automatic t_error();
        logic [31:0] v;
        int base;
        wr(ra(4, 0), 0); wr(ra(4, 4), 32'h7000); wr(ra(4, 5), 32'd8);
        err_inject = 1'b1;
        base = nlog;
        dev_req[4] = 1'b1;
        wr(ra(4, 1), 32'h13);
        wait_mask_set(4, 8'h04);
        err_inject = 1'b0;
        repeat (10) @(negedge clk);
        rd(ra(4, 3), v);  check("R9 error sets ERROR clears RUN", v, 32'h16);
        check("R9 no burst after error", 32'(nlog - base), 1);
        check("R7 irq on error", 32'(irq[4]), 1);
        rd(ra(4, 5), v);  check("R9 count unchanged", v, 8);
        rd(ra(4, 4), v);  check("R9 address unchanged", v, 32'h7000);
        wr(ra(4, 2), 32'h04);
        repeat (10) @(negedge clk);
        rd(ra(4, 3), v);  check("R9 error cleared, still halted", v, 32'h12);
        check("R9 no burst before RUN", 32'(nlog - base), 1);
        wr(ra(4, 1), 32'h01);
        wait_mask_clear(4, 8'h10);
        check("R9 re-armed transfer runs", 32'(nlog - base), 3);
        check("R9 restart address", log_addr[base+1], 32'h7000);
        dev_req[4] = 1'b0;
        wr(ra(4, 2), 32'hFF);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        int mark;
        wr(ra(5, 0), 0); wr(ra(5, 4), 32'h8000); wr(ra(5, 5), 32'd400);
        dev_req[5] = 1'b1;
        wr(ra(5, 1), 32'h13);
        repeat (10) @(negedge clk);
        wr(ra(5, 2), 32'hFF);
        repeat (5) @(negedge clk);
        mark = nlog;
        repeat (20) @(negedge clk);
        check("R3 no burst after stop", 32'(nlog - mark), 0);
        rd(ra(5, 3), v);  check("R3 status zero after stop", v, 0);
        check("R3 irq low after stop", 32'(irq[5]), 0);
        dev_req[5] = 1'b0;
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        int base;
        wr(ra(0, 2), 32'hFF);
        wr(ra(0, 5), 32'd0);
        wr(ra(0, 6), 32'h9000);
        wr(ra(0, 7), 32'd8);
        base = nlog;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ra(0, 1); reg_wdata = 32'h13;
        @(negedge clk);
        reg_wdata = 32'h40;
        @(negedge clk);
        reg_we = 1'b0;
        rd(ra(0, 3), v);  check("R11 set layered on retirement", v, 32'hCB);
        check("R6 zero-count retire has no burst", 32'(nlog - base), 0);
        wr(ra(0, 2), 32'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_setclr();
        t_single_and_stall();
        t_pingpong();
        t_arb();
        t_error();
        t_stop();
        t_same_cycle();
        repeat (5) @(negedge clk);
        summary();
    end

endmodule